// File: doc/BRIEF.md
# Pulse-and-Verify Byte Programming Sequencer

This block sits on the programmer side of a one-time-programmable byte memory. It burns a run of consecutive locations. A start command supplies the first address and the number of bytes. The bytes themselves arrive over a valid/ready source stream. For each byte the sequencer drives the address and the write data onto the memory and settles them. It then fires a fixed-width, active-low program strobe. After the strobe it releases the data bus and reads the location back. If the readback differs from the intended byte, the pulse-and-verify loop repeats. The loop stops when the byte verifies or when the per-address pulse limit is used up.

The two supply-switch requests, programming high voltage and raised core supply, are plain enable outputs. Both stay asserted while a run is active. When the run ends, the block gives a one-cycle done pulse. It then holds a fail flag, the failing address and the number of pulses spent on that address until the next start.

The strobe width is a number of clock cycles derived from the clock frequency and a width in microseconds. Setup, hold and read-access gaps are cycle-count parameters. The source stream is back-pressured: `src_ready` is high only while the sequencer waits for its next byte. A byte moves only in a cycle where `src_valid` and `src_ready` are both high. The source may hold `src_valid` high for any number of cycles without losing the byte.

Top module: `burn_seq`

## Requirements
- R1: While `rst_n` is low: `busy`, `done`, `fail`, `src_ready`, `mem_wdata_oe`, `vpp_en` and `vcc_hi_en` are 0, and `mem_pgm_n` is 1.
- R2: Every low period of `mem_pgm_n` lasts exactly `(CLK_HZ/1000)*PULSE_US/1000` clock cycles.
- R3: `mem_addr` and `mem_wdata` are driven (`mem_wdata_oe`=1) and unchanged for at least `SETUP_CYC` cycles before `mem_pgm_n` falls. They stay unchanged while it is low. The bus stays driven and unchanged for at least `HOLD_CYC` cycles after it rises.
- R4: After each strobe the data bus is released (`mem_wdata_oe`=0). `mem_rdata` is compared in the `ACCESS_CYC`-th released cycle. The sequencer moves to the next address only when the readback equals the byte being written.
- R5: No address receives more than `MAX_PULSES` strobes. If the readback after the last allowed strobe still differs, the run ends with `fail`=1, `fail_addr` set to that address and `fail_pulses` set to `MAX_PULSES`.
- R6: A byte of all ones receives no strobe and is only verified. If that readback differs, the run ends with `fail`=1 and `fail_pulses`=0.
- R7: `vpp_en` and `vcc_hi_en` are both 1 whenever `mem_pgm_n` is low. Both are 0 once the run has ended.
- R8: A `start` asserted while `busy` is 1 has no effect on the run in progress.
- R9: `src_ready` is 1 only while the sequencer waits for a byte. Exactly one byte is taken per address, at a cycle where `src_valid` and `src_ready` are both high. Addresses run upward from `start_addr`.
- R10: The end of a run gives a one-cycle `done` with `busy` already 0. `fail`, `fail_addr` and `fail_pulses` hold until the next accepted start. A start with `byte_count`=0 gives `done` on the next cycle with no strobe and no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | ADDR_W | First address of the run |
| byte_count | input | CNT_W | Number of bytes to burn |
| src_valid | input | 1 | Source byte available |
| src_ready | output | 1 | Sequencer takes a byte this cycle if valid |
| src_data | input | DATA_W | Source byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Data driven to the memory |
| mem_wdata_oe | output | 1 | Programmer drives the data bus |
| mem_rdata | input | DATA_W | Data read back from the memory |
| mem_pgm_n | output | 1 | Active-low program strobe |
| vpp_en | output | 1 | Request for programming high voltage |
| vcc_hi_en | output | 1 | Request for raised core supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run ended on a verify failure |
| fail_addr | output | ADDR_W | Address that failed |
| fail_pulses | output | $clog2(MAX_PULSES+1) | Strobes spent on the failing address |

## Verification
The bench uses a behavioural memory. In it, each cell needs a chosen number of strobes before it takes its value, and it returns inverted data if sampled before the access time has passed. A design that samples the readback too early, or miscounts pulses, shows up as a wrong total strobe count. Directed runs cover these boundaries:
- a cell needing exactly the limit, which must pass;
- a cell needing one more than the limit, which must fail with the count at the limit;
- an all-ones byte over an already programmed cell, which must fail without any strobe;
- a zero-length run.

Randomised runs with stalling source gaps and a start command injected mid-run catch a sequencer that drops or repeats bytes under back-pressure, or that restarts when it should not.

// File: rtl/burn_pkg.sv
package burn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY
  } burn_state_e;
endpackage

// File: rtl/burn_delay.sv
// Loadable down-counter used to time each phase.
module burn_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/burn_walker.sv
// Tracks the current address and the number of bytes still to burn.
module burn_walker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [CNT_W-1:0]  init_count,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      remaining <= '0;
    end else if (init) begin
      addr      <= init_addr;
      remaining <= init_count;
    end else if (step) begin
      addr      <= addr + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  assign last = (remaining == CNT_W'(1));
endmodule

// File: rtl/burn_seq.sv
module burn_seq
  import burn_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 17,
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int ACCESS_CYC = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [ADDR_W-1:0]                 start_addr,
  input  logic [CNT_W-1:0]                  byte_count,
  input  logic                              src_valid,
  output logic                              src_ready,
  input  logic [DATA_W-1:0]                 src_data,
  output logic [ADDR_W-1:0]                 mem_addr,
  output logic [DATA_W-1:0]                 mem_wdata,
  output logic                              mem_wdata_oe,
  input  logic [DATA_W-1:0]                 mem_rdata,
  output logic                              mem_pgm_n,
  output logic                              vpp_en,
  output logic                              vcc_hi_en,
  output logic                              busy,
  output logic                              done,
  output logic                              fail,
  output logic [ADDR_W-1:0]                 fail_addr,
  output logic [$clog2(MAX_PULSES+1)-1:0]   fail_pulses
);
  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int SPAN_A    = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int SPAN_B    = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int LONGEST   = (SPAN_A > SPAN_B) ? SPAN_A : SPAN_B;
  localparam int TMR_W     = $clog2(LONGEST + 1);
  localparam int PC_W      = $clog2(MAX_PULSES + 1);
  localparam logic [TMR_W-1:0] T_SETUP  = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] T_PULSE  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] T_HOLD   = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] T_ACCESS = TMR_W'(ACCESS_CYC - 1);
  localparam logic [DATA_W-1:0] ERASED  = '1;

  burn_state_e       st, nxt;
  logic [DATA_W-1:0] wdata;
  logic [PC_W-1:0]   pcnt;
  logic              t_load, t_zero;
  logic [TMR_W-1:0]  t_val;
  logic              accept, bump, adv, finish, bad, begin_run, last;
  logic [ADDR_W-1:0] addr;

  burn_delay #(.W(TMR_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  burn_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .init(begin_run), .init_addr(start_addr),
    .init_count(byte_count), .step(adv), .addr(addr), .last(last)
  );

  always_comb begin
    nxt       = st;
    t_load    = 1'b0;
    t_val     = '0;
    accept    = 1'b0;
    bump      = 1'b0;
    adv       = 1'b0;
    finish    = 1'b0;
    bad       = 1'b0;
    begin_run = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        begin_run = 1'b1;
        if (byte_count == '0) finish = 1'b1;
        else                  nxt = ST_FETCH;
      end
      ST_FETCH: if (src_valid) begin
        accept = 1'b1;
        t_load = 1'b1;
        if (src_data == ERASED) begin
          nxt   = ST_VERIFY;
          t_val = T_ACCESS;
        end else begin
          nxt   = ST_SETUP;
          t_val = T_SETUP;
        end
      end
      ST_SETUP: if (t_zero) begin
        nxt    = ST_PULSE;
        t_load = 1'b1;
        t_val  = T_PULSE;
        bump   = 1'b1;
      end
      ST_PULSE: if (t_zero) begin
        nxt    = ST_HOLD;
        t_load = 1'b1;
        t_val  = T_HOLD;
      end
      ST_HOLD: if (t_zero) begin
        nxt    = ST_VERIFY;
        t_load = 1'b1;
        t_val  = T_ACCESS;
      end
      ST_VERIFY: if (t_zero) begin
        if (mem_rdata == wdata) begin
          if (last) begin
            finish = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            adv = 1'b1;
            nxt = ST_FETCH;
          end
        end else if (pcnt == PC_W'(MAX_PULSES) || wdata == ERASED) begin
          finish = 1'b1;
          bad    = 1'b1;
          nxt    = ST_IDLE;
        end else begin
          nxt    = ST_SETUP;
          t_load = 1'b1;
          t_val  = T_SETUP;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      wdata       <= '0;
      pcnt        <= '0;
      done        <= 1'b0;
      fail        <= 1'b0;
      fail_addr   <= '0;
      fail_pulses <= '0;
    end else begin
      st   <= nxt;
      done <= finish;
      if (accept)    wdata <= src_data;
      if (accept)    pcnt  <= '0;
      else if (bump) pcnt  <= pcnt + 1'b1;
      if (begin_run) begin
        fail        <= 1'b0;
        fail_addr   <= '0;
        fail_pulses <= '0;
      end
      if (bad) begin
        fail        <= 1'b1;
        fail_addr   <= addr;
        fail_pulses <= pcnt;
      end
    end
  end

  assign src_ready    = (st == ST_FETCH);
  assign mem_addr     = addr;
  assign mem_wdata    = wdata;
  assign mem_wdata_oe = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD);
  assign mem_pgm_n    = (st != ST_PULSE);
  assign busy         = (st != ST_IDLE);
  assign vpp_en       = busy;
  assign vcc_hi_en    = busy;
endmodule

// File: rtl/burn_seq_chk.sv
module burn_seq_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            mem_pgm_n,
  input logic                            mem_wdata_oe,
  input logic [ADDR_W-1:0]               mem_addr,
  input logic [DATA_W-1:0]               mem_wdata,
  input logic                            src_valid,
  input logic                            src_ready,
  input logic                            vpp_en,
  input logic                            vcc_hi_en,
  input logic                            busy,
  input logic                            done,
  input logic                            fail,
  input logic [$clog2(MAX_PULSES+1)-1:0] fail_pulses
);
  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;

  int                low_run, drv_run, since_rise, per_addr;
  logic              pgm_q;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= 0;
      drv_run    <= 0;
      since_rise <= 0;
      per_addr   <= 0;
      pgm_q      <= 1'b1;
      a_q        <= '0;
      d_q        <= '0;
    end else begin
      low_run <= mem_pgm_n ? 0 : low_run + 1;
      if (!mem_wdata_oe)                             drv_run <= 0;
      else if (mem_addr != a_q || mem_wdata != d_q)  drv_run <= 1;
      else                                           drv_run <= drv_run + 1;
      if (!mem_pgm_n)                 since_rise <= 0;
      else if (since_rise < HOLD_CYC) since_rise <= since_rise + 1;
      if (src_valid && src_ready)     per_addr <= 0;
      else if (pgm_q && !mem_pgm_n)   per_addr <= per_addr + 1;
      pgm_q <= mem_pgm_n;
      a_q   <= mem_addr;
      d_q   <= mem_wdata;
    end
  end

  a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> low_run == PULSE_CYC);

  a_r3_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_pgm_n) |-> drv_run >= SETUP_CYC);

  a_r3_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> mem_wdata_oe && $stable(mem_addr) && $stable(mem_wdata));

  a_r3_hold_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wdata_oe) |-> since_rise >= HOLD_CYC);

  a_r5_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    per_addr <= MAX_PULSES);

  a_r5_fail_count: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> fail_pulses <= MAX_PULSES);

  a_r7_supply_on: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> vpp_en && vcc_hi_en);

  a_r9_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> busy && !mem_wdata_oe && mem_pgm_n);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind burn_seq burn_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US),
  .MAX_PULSES(MAX_PULSES), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_pgm_n(mem_pgm_n), .mem_wdata_oe(mem_wdata_oe),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .src_valid(src_valid),
  .src_ready(src_ready), .vpp_en(vpp_en), .vcc_hi_en(vcc_hi_en), .busy(busy),
  .done(done), .fail(fail), .fail_pulses(fail_pulses)
);

// File: tb/burn_seq_test.sv
module burn_seq_test;
  localparam int AW = 8, DW = 8, CW = 8;
  localparam int HZ = 100_000, PUS = 100, MAXP = 25;
  localparam int SU = 2, HO = 2, AC = 3;
  localparam int PW = (HZ / 1000) * PUS / 1000;
  localparam int PCW = $clog2(MAXP + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [DW-1:0] src_data = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_wdata_oe;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_pgm_n, vpp_en, vcc_hi_en, busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [PCW-1:0] fail_pulses;

  burn_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .CLK_HZ(HZ), .PULSE_US(PUS),
    .MAX_PULSES(MAXP), .SETUP_CYC(SU), .HOLD_CYC(HO), .ACCESS_CYC(AC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_pgm_n(mem_pgm_n),
    .vpp_en(vpp_en), .vcc_hi_en(vcc_hi_en), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_pulses(fail_pulses)
  );

  // Behavioural memory: cell takes its value after need[] strobes.
  logic [7:0] init_v [256];
  int         need   [256];
  int         got    [256];
  logic [7:0] pval   [256];
  logic       clr_mem = 1'b0;
  int         tot_pulses, low_len, drv_len, oe_low;
  logic       pgm_q;
  logic [7:0] a_q, d_q;
  int         m_chk = 0, m_fail = 0;

  function automatic logic [7:0] cell_now(input int a);
    return (got[a] >= need[a]) ? (init_v[a] & pval[a]) : init_v[a];
  endfunction

  task automatic mchk(input bit ok, input string msg, input int act, input int exp);
    m_chk++;
    if (!ok) begin
      m_fail++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n || clr_mem) begin
      for (int i = 0; i < 256; i++) got[i] = 0;
      tot_pulses = 0; low_len = 0; drv_len = 0; oe_low = 0;
      pgm_q = 1'b1; a_q = '0; d_q = '0;
    end else begin
      if (pgm_q && !mem_pgm_n) begin
        tot_pulses++;
        got[mem_addr]++;
        pval[mem_addr] = mem_wdata;
        mchk(vpp_en && vcc_hi_en, "R7 supplies during strobe", int'(vpp_en), 1);
        mchk(drv_len >= SU, "R3 setup before strobe", drv_len, SU);
      end
      if (!mem_pgm_n) low_len++;
      else begin
        if (!pgm_q) mchk(low_len == PW, "R2 strobe width", low_len, PW);
        low_len = 0;
      end
      if (!mem_wdata_oe) drv_len = 0;
      else if (mem_addr != a_q || mem_wdata != d_q) drv_len = 1;
      else drv_len++;
      if (mem_wdata_oe) oe_low = 0; else oe_low++;
      pgm_q = mem_pgm_n; a_q = mem_addr; d_q = mem_wdata;
    end
    mem_rdata = (!mem_wdata_oe && oe_low >= AC) ? cell_now(int'(mem_addr))
                                                : ~cell_now(int'(mem_addr));
  end

  // Bench bookkeeping
  int n_chk = 0, n_fail = 0;
  logic [7:0] jd [64];
  int  cons;
  bit  job_over;
  bit  e_fail; int e_addr, e_pul, e_tot, e_cons;
  bit  d_busy, d_fail, d_seen; int d_addr, d_pul;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic blank_mem();
    for (int a = 0; a < 256; a++) begin
      init_v[a] = 8'hFF;
      need[a]   = 1;
    end
  endtask

  task automatic expect_job(input int sa, input int n);
    e_fail = 0; e_addr = 0; e_pul = 0; e_tot = 0; e_cons = 0;
    for (int i = 0; i < n; i++) begin
      int a;
      a = (sa + i) & 255;
      e_cons++;
      if (jd[i] == 8'hFF) begin
        if (init_v[a] != 8'hFF) begin e_fail = 1; e_addr = a; e_pul = 0; break; end
      end else if (need[a] <= MAXP) e_tot += need[a];
      else begin e_tot += MAXP; e_fail = 1; e_addr = a; e_pul = MAXP; break; end
    end
  endtask

  task automatic drive_src(input int n);
    for (int i = 0; i < n; i++) begin
      bit hs;
      if (job_over) break;
      repeat ($urandom_range(0, 3)) begin @(posedge clk); #1; end
      src_valid = 1'b1;
      src_data  = jd[i];
      hs = 1'b0;
      while (!hs && !job_over) begin
        @(negedge clk);
        hs = src_ready;
        @(posedge clk); #1;
      end
      if (hs) cons++;
      src_valid = 1'b0;
      src_data  = 8'($urandom);
    end
  endtask

  task automatic wait_done();
    int c;
    c = 0;
    do begin @(negedge clk); c++; end while (!done && c < 30000);
    d_seen = done; d_busy = busy; d_fail = fail;
    d_addr = int'(fail_addr); d_pul = int'(fail_pulses);
    job_over = 1'b1;
  endtask

  task automatic poke(input int sa);
    repeat (20) @(negedge clk);
    if (busy) begin
      @(posedge clk); #1;
      start = 1'b1; start_addr = 8'(sa ^ 8'h40); byte_count = 8'd3;
      @(posedge clk); #1;
      start = 1'b0;
    end
  endtask

  task automatic run_job(input int sa, input int n, input bit intr, input string tag);
    @(posedge clk); #1 clr_mem = 1'b1;
    @(posedge clk); #1 clr_mem = 1'b0;
    expect_job(sa, n);
    cons = 0; job_over = 1'b0;
    @(posedge clk); #1;
    start = 1'b1; start_addr = 8'(sa); byte_count = 8'(n);
    @(posedge clk); #1;
    start = 1'b0;
    fork
      drive_src(n);
      wait_done();
      if (intr) poke(sa);
    join
    chk(d_seen, {tag, " R10 done seen"}, int'(d_seen), 1);
    chk(!d_busy, {tag, " R10 busy low at done"}, int'(d_busy), 0);
    chk(d_fail == e_fail, {tag, " R5 R6 fail flag"}, int'(d_fail), int'(e_fail));
    if (e_fail) begin
      chk(d_addr == e_addr, {tag, " R5 fail address"}, d_addr, e_addr);
      chk(d_pul == e_pul, {tag, " R5 R6 fail pulse count"}, d_pul, e_pul);
    end
    chk(tot_pulses == e_tot, {tag, " R4 total strobes"}, tot_pulses, e_tot);
    chk(cons == e_cons, {tag, " R9 bytes consumed"}, cons, e_cons);
    chk(!vpp_en && !vcc_hi_en, {tag, " R7 supplies released"}, int'(vpp_en), 0);
    for (int i = 0; i < e_cons - int'(e_fail); i++) begin
      int a;
      a = (sa + i) & 255;
      chk(cell_now(a) == jd[i], {tag, " R4 programmed content"}, int'(cell_now(a)), int'(jd[i]));
    end
    if (intr) chk(tot_pulses == e_tot && cons == e_cons, {tag, " R8 start while busy ignored"},
                  cons, e_cons);
    repeat (2) @(negedge clk);
    chk(fail == e_fail, {tag, " R10 fail flag holds"}, int'(fail), int'(e_fail));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk + 1, n_fail + m_fail + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    blank_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fail, "R1 status in reset", int'(busy), 0);
    chk(mem_pgm_n && !mem_wdata_oe, "R1 strobe idle in reset", int'(mem_pgm_n), 1);
    chk(!vpp_en && !vcc_hi_en && !src_ready, "R1 supplies off in reset", int'(vpp_en), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R10 zero-length run
    run_job(10, 0, 1'b0, "zero");

    // R6 all-ones bytes over blank cells
    blank_mem();
    for (int i = 0; i < 6; i++) jd[i] = 8'hFF;
    run_job(30, 6, 1'b0, "ones");

    // R6 all-ones byte over programmed cell
    blank_mem();
    jd[0] = 8'h12; jd[1] = 8'hFF; jd[2] = 8'h34;
    init_v[51] = 8'h00;
    run_job(50, 3, 1'b0, "ones_bad");

    // R5 exactly at the limit passes
    blank_mem();
    jd[0] = 8'hA5; jd[1] = 8'h3C; jd[2] = 8'h00;
    need[81] = MAXP;
    run_job(80, 3, 1'b0, "limit");

    // R5 one over the limit fails
    blank_mem();
    jd[0] = 8'h01; jd[1] = 8'h02; jd[2] = 8'h03; jd[3] = 8'h04;
    need[102] = MAXP + 1;
    run_job(100, 4, 1'b0, "over");

    // Random runs, R8 injected in one, R9 gaps everywhere
    for (int j = 0; j < 8; j++) begin
      int sa, n;
      blank_mem();
      sa = $urandom_range(0, 200);
      n  = (j == 3) ? 12 : $urandom_range(1, 20);
      for (int i = 0; i < n; i++) begin
        jd[i] = ($urandom_range(0, 5) == 0 && j != 3) ? 8'hFF : 8'($urandom_range(0, 254));
        need[(sa + i) & 255] = ($urandom_range(0, 29) == 0) ? 30 : $urandom_range(1, 3);
      end
      if (j == 3) for (int i = 0; i < n; i++) need[(sa + i) & 255] = 2;
      run_job(sa, n, j == 3, "rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk, n_fail + m_fail);
    $finish;
  end
endmodule